// File: doc/BRIEF.md
# Key-Gated Write Protection Controller

This unit guards write traffic aimed at a processing subsystem's local resources. It holds two software-visible registers behind a small register port: a key register and a protection configuration register. The configuration register can only be changed after a specific 32-bit pattern has been written to the key register. Writing zero to the key register closes it again. Any other key value leaves the lock state as it is. The key register never echoes the written pattern. It reads back a single bit that shows whether the configuration register is currently open.

The seven configuration bits drive a combinational filter. The filter judges each write request, which carries a region code and a master ID, and reports allow or block in the same cycle. The debug instruction-memory windows and the shared configuration space are closed to every writer when their bit is set. The two data memories behave differently: when their bit is set, only the owning core may still write them. Reads always pass. A sticky flag records any configuration write that was dropped because the block was locked.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset the block is locked, the key register (offset 0x0) reads 0, the config register (offset 0x4) reads 0, the drop flag is 0, and every request is allowed.
- R2: A write of 0x83E70B13 to offset 0x0 unlocks the block, and from the next cycle the key register reads 0x00000001.
- R3: A write of 0x00000000 to offset 0x0 locks the block, and the key register then reads 0. A write of any other value to offset 0x0 leaves the lock state unchanged, whether the block is locked or unlocked.
- R4: While unlocked, a write to offset 0x4 stores bits 6:0 from the next cycle. Bits 31:7 always read as zero.
- R5: While locked, a write to offset 0x4 leaves the config unchanged and sets the sticky drop flag. Any write to offset 0x0 clears that flag.
- R6: Config bits 0, 1, 2 and 3 block every write, from any master, to the debug instruction-memory regions with codes 3 (core 0 and its transmit partner), 4 (core 1 and its transmit partner), 5 (real-time unit 0) and 6 (real-time unit 1).
- R7: Config bit 4 blocks every write, from any master, to the shared configuration region (code 2).
- R8: Config bit 5 blocks writes to data memory 0 (region 0) unless the master ID is 0, meaning core 0. Config bit 6 blocks writes to data memory 1 (region 1) unless the master ID is 1, meaning core 1. When these bits are clear, both data memories are open to all masters.
- R9: The filter decision is combinational, with req_blocked equal to the inverse of req_allow. A request that is a read, that is not valid, or that targets region 7 is never blocked.
- R10: Register offsets other than 0x0 and 0x4 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at reg_addr (combinational) |
| cfg_drop | output | 1 | Sticky flag: a config write was dropped while locked |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | Request is a write |
| req_region | input | 3 | Target region code |
| req_master | input | 3 | Requesting master ID |
| req_allow | output | 1 | Request may proceed |
| req_blocked | output | 1 | Write request rejected |

## Verification
The bench targets four kinds of mistake.

- **Key handling.** A wrong key must not unlock the block, and it must not lock the block while it is unlocked. A design that treats every nonzero value as the key would open on garbage. A design that locks on any non-key value would close unexpectedly.
- **Config width.** It writes all ones to the config register and reads the value back. A design that stores or reflects the reserved bits would return more than seven ones.
- **Bit-to-region mapping.** Each config bit is set on its own, and all eight regions are swept for several masters. A swapped or shared bit shows up as a block in the wrong region.
- **Data-memory ownership.** Both memories are driven by their owner and by other masters. A design that blocks everyone, or that checks the wrong owner ID, fails there.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 4;
    localparam int unsigned CFG_W    = 7;
    localparam int unsigned REGION_W = 3;
    localparam int unsigned MASTER_W = 3;

    localparam logic [DATA_W-1:0] UNLOCK_PATTERN = 32'h83E7_0B13;
    localparam logic [ADDR_W-1:0] OFS_KEY = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CFG = 4'h4;

    // config bit positions (behaviour-bearing)
    localparam int unsigned BIT_DBG_C0  = 0;
    localparam int unsigned BIT_DBG_C1  = 1;
    localparam int unsigned BIT_DBG_RT0 = 2;
    localparam int unsigned BIT_DBG_RT1 = 3;
    localparam int unsigned BIT_SHCFG   = 4;
    localparam int unsigned BIT_DMEM0   = 5;
    localparam int unsigned BIT_DMEM1   = 6;

    typedef enum logic [REGION_W-1:0] {
        RGN_DMEM0   = 3'd0,
        RGN_DMEM1   = 3'd1,
        RGN_SHCFG   = 3'd2,
        RGN_DBG_C0  = 3'd3,
        RGN_DBG_C1  = 3'd4,
        RGN_DBG_RT0 = 3'd5,
        RGN_DBG_RT1 = 3'd6,
        RGN_OPEN    = 3'd7
    } region_e;

    localparam logic [MASTER_W-1:0] MST_CORE0 = 3'd0;
    localparam logic [MASTER_W-1:0] MST_CORE1 = 3'd1;

    typedef struct packed {
        logic             unlocked;
        logic [CFG_W-1:0] cfg;
        logic             drop;
    } prot_state_t;

endpackage

// File: rtl/wprot_regs.sv
module wprot_regs
    import wprot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              unlocked,
    output logic [CFG_W-1:0]  cfg,
    output logic              drop
);

    prot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (addr)
                OFS_KEY: begin
                    if (wdata == UNLOCK_PATTERN) begin
                        st_d.unlocked = 1'b1;
                    end else if (wdata == '0) begin
                        st_d.unlocked = 1'b0;
                    end
                    st_d.drop = 1'b0;
                end
                OFS_CFG: begin
                    if (st_q.unlocked) begin
                        st_d.cfg = wdata[CFG_W-1:0];
                    end else begin
                        st_d.drop = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (addr)
            OFS_KEY: rdata = DATA_W'(st_q.unlocked);
            OFS_CFG: rdata = DATA_W'(st_q.cfg);
            default: rdata = '0;
        endcase
    end

    assign unlocked = st_q.unlocked;
    assign cfg      = st_q.cfg;
    assign drop     = st_q.drop;

endmodule

// File: rtl/wprot_filter.sv
module wprot_filter
    import wprot_pkg::*;
(
    input  logic [CFG_W-1:0]    cfg,
    input  logic                valid,
    input  logic                write,
    input  logic [REGION_W-1:0] region,
    input  logic [MASTER_W-1:0] master,
    output logic                allow,
    output logic                blocked
);

    logic hit;

    always_comb begin
        unique case (region_e'(region))
            RGN_DMEM0:   hit = cfg[BIT_DMEM0] && (master != MST_CORE0);
            RGN_DMEM1:   hit = cfg[BIT_DMEM1] && (master != MST_CORE1);
            RGN_SHCFG:   hit = cfg[BIT_SHCFG];
            RGN_DBG_C0:  hit = cfg[BIT_DBG_C0];
            RGN_DBG_C1:  hit = cfg[BIT_DBG_C1];
            RGN_DBG_RT0: hit = cfg[BIT_DBG_RT0];
            RGN_DBG_RT1: hit = cfg[BIT_DBG_RT1];
            default:     hit = 1'b0;
        endcase
    end

    assign blocked = valid && write && hit;
    assign allow   = !blocked;

endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
    import wprot_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                cfg_drop,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [REGION_W-1:0] req_region,
    input  logic [MASTER_W-1:0] req_master,
    output logic                req_allow,
    output logic                req_blocked
);

    logic             unlocked;
    logic [CFG_W-1:0] cfg;

    wprot_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .unlocked (unlocked),
        .cfg      (cfg),
        .drop     (cfg_drop)
    );

    wprot_filter u_filter (
        .cfg     (cfg),
        .valid   (req_valid),
        .write   (req_write),
        .region  (req_region),
        .master  (req_master),
        .allow   (req_allow),
        .blocked (req_blocked)
    );

    p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_KEY && reg_wdata == UNLOCK_PATTERN) |=> unlocked);

    p_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_KEY && reg_wdata == '0) |=> !unlocked);

    p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CFG && !unlocked) |=> $stable(cfg));

    p_drop_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CFG && !unlocked) |=> cfg_drop);

    p_owner_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_region == RGN_DMEM0 && req_master == MST_CORE0) |-> !req_blocked);

    p_read_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |-> req_allow);

endmodule

// File: tb/test_wprot_ctrl.sv
module test_wprot_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        cfg_drop;
    logic        req_valid, req_write;
    logic [2:0]  req_region, req_master;
    logic        req_allow, req_blocked;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [31:0] KEY = 32'h83E7_0B13;

    always #2 clk = ~clk;

    wprot_ctrl i_wprot_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_drop(cfg_drop),
        .req_valid(req_valid), .req_write(req_write), .req_region(req_region),
        .req_master(req_master), .req_allow(req_allow), .req_blocked(req_blocked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic req_chk(input string req, input logic [2:0] rgn, input logic [2:0] mst,
                           input logic w, input logic exp_blk);
        req_valid = 1'b1; req_write = w; req_region = rgn; req_master = mst;
        #1;
        chk(req, {30'b0, req_blocked, req_allow}, {30'b0, exp_blk, !exp_blk});
        req_valid = 1'b0;
    endtask

    function automatic logic exp_block(input logic [6:0] c, input logic [2:0] rgn, input logic [2:0] mst);
        case (rgn)
            3'd0: return c[5] && mst != 3'd0;
            3'd1: return c[6] && mst != 3'd1;
            3'd2: return c[4];
            3'd3: return c[0];
            3'd4: return c[1];
            3'd5: return c[2];
            3'd6: return c[3];
            default: return 1'b0;
        endcase
    endfunction

    task automatic sweep(input string req, input logic [6:0] c);
        @(negedge clk);
        for (int r = 0; r < 8; r++) begin
            for (int m = 0; m < 7; m += 3) begin
                req_chk(req, 3'(r), 3'(m), 1'b1, exp_block(c, 3'(r), 3'(m)));
            end
        end
    endtask

    task automatic t_reset();
        rd_chk("R1 key", 4'h0, 32'h0);
        rd_chk("R1 cfg", 4'h4, 32'h0);
        chk("R1 drop", {31'b0, cfg_drop}, 32'h0);
        sweep("R1 open", 7'h00);
    endtask

    task automatic t_locked_cfg();
        wr(4'h4, 32'h0000_007F);
        rd_chk("R5 cfg unchanged", 4'h4, 32'h0);
        chk("R5 drop set", {31'b0, cfg_drop}, 32'h1);
        sweep("R5 no effect", 7'h00);
    endtask

    task automatic t_wrong_key();
        wr(4'h0, 32'h1234_5678);
        rd_chk("R3 wrong key stays locked", 4'h0, 32'h0);
        chk("R5 key write clears drop", {31'b0, cfg_drop}, 32'h0);
        wr(4'h0, 32'h83E7_0B12);
        wr(4'h4, 32'h0000_0001);
        rd_chk("R3 near key still locked", 4'h4, 32'h0);
    endtask

    task automatic t_unlock();
        wr(4'h0, KEY);
        rd_chk("R2 unlocked readback", 4'h0, 32'h1);
        chk("R5 drop cleared", {31'b0, cfg_drop}, 32'h0);
        wr(4'h0, 32'hDEAD_BEEF);
        rd_chk("R3 wrong key keeps unlocked", 4'h0, 32'h1);
    endtask

    task automatic t_cfg_update();
        wr(4'h4, 32'hFFFF_FFFF);
        rd_chk("R4 reserved bits zero", 4'h4, 32'h0000_007F);
        sweep("R6 R7 R8 all on", 7'h7F);
        @(negedge clk);
        for (int r = 0; r < 8; r++) begin
            req_chk("R9 read passes", 3'(r), 3'd6, 1'b0, 1'b0);
        end
        req_valid = 1'b0; req_write = 1'b1; req_region = 3'd3;
        #1;
        chk("R9 invalid passes", {31'b0, req_blocked}, 32'h0);
    endtask

    task automatic t_single_bits();
        for (int b = 0; b < 7; b++) begin
            wr(4'h4, 32'(1) << b);
            rd_chk("R4 single bit", 4'h4, 32'(1) << b);
            sweep("R6 R7 R8 single bit", 7'(1 << b));
        end
    endtask

    task automatic t_dmem_owner();
        wr(4'h4, 32'h0000_0060);
        @(negedge clk);
        req_chk("R8 dmem0 owner", 3'd0, 3'd0, 1'b1, 1'b0);
        req_chk("R8 dmem0 core1", 3'd0, 3'd1, 1'b1, 1'b1);
        req_chk("R8 dmem0 host", 3'd0, 3'd6, 1'b1, 1'b1);
        req_chk("R8 dmem1 owner", 3'd1, 3'd1, 1'b1, 1'b0);
        req_chk("R8 dmem1 core0", 3'd1, 3'd0, 1'b1, 1'b1);
        req_chk("R8 dmem1 rt", 3'd1, 3'd4, 1'b1, 1'b1);
    endtask

    task automatic t_unmapped();
        wr(4'h8, 32'hFFFF_FFFF);
        wr(4'hC, 32'h0000_0001);
        rd_chk("R10 unmapped reads 0", 4'h8, 32'h0);
        rd_chk("R10 unmapped reads 0 c", 4'hC, 32'h0);
        rd_chk("R10 cfg untouched", 4'h4, 32'h0000_0060);
        rd_chk("R10 lock untouched", 4'h0, 32'h1);
    endtask

    task automatic t_lock();
        wr(4'h0, 32'h0);
        rd_chk("R3 zero locks", 4'h0, 32'h0);
        wr(4'h4, 32'h0000_0000);
        rd_chk("R5 cfg held after lock", 4'h4, 32'h0000_0060);
        chk("R5 drop set again", {31'b0, cfg_drop}, 32'h1);
        sweep("R8 filter still active", 7'h60);
    endtask

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        req_valid = 1'b0; req_write = 1'b0; req_region = '0; req_master = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_locked_cfg();
        t_wrong_key();
        t_unlock();
        t_cfg_update();
        t_single_bits();
        t_dmem_owner();
        t_unmapped();
        t_lock();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule